// File: doc/BRIEF.md
# JTAG Boot Mailbox Data Register

This block is a ten-bit test-access data register that serves as a one-byte mailbox between an external JTAG host and the on-chip boot loader firmware. It only responds when three conditions hold: boot programming is enabled, the programming source code is 00, and the debug instruction is latched in the TAP. Whenever boot programming is enabled with source 00, the block asks the regular debug state machines to stay idle.

Each data-register scan moves one ten-bit word. Bits 9:2 carry a data byte and bits 1:0 carry a status code, and the word is shifted least significant bit first. At the falling TCK edge in Update-DR, one event does three things at once. The host's byte goes to a receive register that the CPU can read. The firmware's holding byte is moved into a transmit stage, which the next capture presents to the host. The firmware's transmit-complete flag is cleared. A single-cycle strobe in the CPU clock domain tells the firmware that a new byte has arrived.

All TAP inputs are oversampled by the CPU clock through a synchroniser, so every register of the block lives in one clock domain.

Top module: `jtag_boot_mailbox`

## Requirements
- R1: Mailbox mode is active only when `boot_prog_en` is 1, `boot_src` is 00 and `ir_debug_sel` is 1. Outside this mode, `tdo` is 0, scans leave `rx_byte` unchanged and no `rx_strobe` pulse is produced.
- R2: `dbg_sm_hold` is 1 exactly when `boot_prog_en` is 1 and `boot_src` is 00, whatever the value of `ir_debug_sel`.
- R3: At a rising TCK edge in Capture-DR, the shift stage loads the transmit-stage byte into bits 9:2 and a status code into bits 1:0. The code is 11 (loader valid) if the flag that travelled with that byte was 1, and 10 (loader busy) otherwise. Codes 00 and 01 are never loaded.
- R4: At each rising TCK edge in Shift-DR, the word moves one place toward bit 0 and `tdi` enters at bit 9. `tdo` presents bit 0, so the word leaves least significant bit first.
- R5: At the falling TCK edge in Update-DR, `rx_byte` takes bits 9:2 of the shifted-in word. In the same event, the transmit stage takes the holding byte and the travelling flag takes the current TXC value.
- R6: The Update-DR event clears TXC, unless a CPU flag write falls in the same cycle.
- R7: A CPU write to the holding byte or to TXC during a scan does not change the bits shifted out in that scan.
- R8: A CPU write in the same clock cycle as the Update-DR event counts as arriving after it. TXC takes the written value, the holding register takes the new byte, and the transmit stage receives the holding byte from before the write.
- R9: Each Update-DR event in mailbox mode produces exactly one `rx_strobe` pulse, one clock cycle wide.
- R10: After reset, TXC is 0, `rx_byte` is 0 and `rx_strobe` is 0. The first captured word is byte 00 with status 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock; all registers and TAP oversampling |
| rst_n | input | 1 | Active-low asynchronous reset |
| tck | input | 1 | Test clock, oversampled |
| tdi | input | 1 | Serial data from host |
| tap_capture_dr | input | 1 | TAP is in Capture-DR |
| tap_shift_dr | input | 1 | TAP is in Shift-DR |
| tap_update_dr | input | 1 | TAP is in Update-DR |
| ir_debug_sel | input | 1 | Debug instruction is latched |
| boot_prog_en | input | 1 | Boot programming requested |
| boot_src | input | 2 | Programming source select, 00 = JTAG |
| tdo | output | 1 | Serial data to host |
| dbg_sm_hold | output | 1 | Keeps the debug state machines disabled |
| cpu_hold_we | input | 1 | Write strobe for the holding byte |
| cpu_hold_data | input | 8 | Holding byte write data |
| cpu_txc_we | input | 1 | Write strobe for TXC |
| cpu_txc_val | input | 1 | TXC write value |
| txc | output | 1 | Current transmit-complete flag |
| rx_byte | output | 8 | Last byte received from host |
| rx_strobe | output | 1 | One-cycle pulse per received byte |

## Verification
The Update-DR exchange and a firmware write of both the holding byte and TXC can fall in the same clock cycle. The bench provokes this by counting synchroniser stages from the falling TCK edge and placing both writes in the exact cycle in which the update event is decoded. Four scans then judge the outcome. The colliding scan must still output the older byte. TXC must stay set. The next scan must present the pre-collision holding byte as valid, and only the scan after it may present the byte written in the collision cycle.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int DATA_W = 8;
    localparam int STAT_W = 2;
    localparam int WORD_W = DATA_W + STAT_W;
    localparam int SRC_W  = 2;

    localparam logic [SRC_W-1:0]  SRC_JTAG   = 2'b00;
    localparam logic [STAT_W-1:0] STAT_BUSY  = 2'b10;
    localparam logic [STAT_W-1:0] STAT_VALID = 2'b11;

    typedef logic [DATA_W-1:0] mbx_byte_t;
    typedef logic [WORD_W-1:0] mbx_word_t;

    // raw TAP-side inputs, carried through the synchroniser as one bus
    typedef struct packed {
        logic             tck;
        logic             tdi;
        logic             cap;
        logic             shf;
        logic             upd;
        logic             ir_dbg;
        logic             prog_en;
        logic [SRC_W-1:0] src;
    } tap_in_t;
endpackage

// File: rtl/mbx_in_sync.sv
module mbx_in_sync #(
    parameter int W      = 9,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/mbx_tap_events.sv
module mbx_tap_events
    import mbx_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  tap_in_t s,
    output logic    mode_hold,
    output logic    mode_active,
    output logic    cap_ev,
    output logic    shf_ev,
    output logic    upd_ev,
    output logic    tdi_bit
);
    typedef struct packed {
        logic tck_prev;
    } ev_state_t;

    ev_state_t st_d, st_q;
    logic      rise, fall;

    always_comb begin
        st_d          = st_q;
        st_d.tck_prev = s.tck;
        rise          = s.tck & ~st_q.tck_prev;
        fall          = ~s.tck & st_q.tck_prev;
        mode_hold     = s.prog_en && (s.src == SRC_JTAG);
        mode_active   = mode_hold && s.ir_dbg;
        cap_ev        = mode_active && rise && s.cap;
        shf_ev        = mode_active && rise && s.shf && !s.cap;
        upd_ev        = mode_active && fall && s.upd;
        tdi_bit       = s.tdi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // an update event can never directly follow another
    p_upd_spaced_r9: assert property (@(posedge clk) disable iff (!rst_n)
        upd_ev |=> !upd_ev);
endmodule

// File: rtl/mbx_shift_stage.sv
module mbx_shift_stage
    import mbx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cap_ev,
    input  logic      shf_ev,
    input  logic      upd_ev,
    input  logic      tdi_bit,
    input  mbx_byte_t hold_byte,
    input  logic      txc_flag,
    output logic      tdo_bit,
    output mbx_byte_t host_byte
);
    typedef struct packed {
        mbx_word_t sh;
        mbx_byte_t tx;
        logic      txv;
    } sh_state_t;

    sh_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cap_ev) begin
            st_d.sh = {st_q.tx, (st_q.txv ? STAT_VALID : STAT_BUSY)};
        end else if (shf_ev) begin
            st_d.sh = {tdi_bit, st_q.sh[WORD_W-1:1]};
        end
        if (upd_ev) begin
            st_d.tx  = hold_byte;
            st_d.txv = txc_flag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tdo_bit   = st_q.sh[0];
    assign host_byte = st_q.sh[WORD_W-1:STAT_W];

    p_status_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_ev |=> (st_q.sh[STAT_W-1:0] == STAT_BUSY || st_q.sh[STAT_W-1:0] == STAT_VALID));

    p_shift_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_ev || shf_ev) |=> $stable(st_q.sh));

    p_tx_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_ev |=> (st_q.tx == $past(hold_byte)) && (st_q.txv == $past(txc_flag)));
endmodule

// File: rtl/mbx_fw_regs.sv
module mbx_fw_regs
    import mbx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      upd_ev,
    input  mbx_byte_t host_byte,
    input  logic      hold_we,
    input  mbx_byte_t hold_wdata,
    input  logic      txc_we,
    input  logic      txc_wval,
    output mbx_byte_t hold_byte,
    output logic      txc_flag,
    output mbx_byte_t rx_byte,
    output logic      rx_strobe
);
    typedef struct packed {
        mbx_byte_t hold;
        logic      txc;
        mbx_byte_t rx;
        logic      stb;
    } fw_state_t;

    fw_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.stb = upd_ev;
        if (upd_ev) begin
            st_d.rx  = host_byte;
            st_d.txc = 1'b0;
        end
        // a CPU write in the event cycle is ordered after the event
        if (txc_we)  st_d.txc  = txc_wval;
        if (hold_we) st_d.hold = hold_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hold_byte = st_q.hold;
    assign txc_flag  = st_q.txc;
    assign rx_byte   = st_q.rx;
    assign rx_strobe = st_q.stb;

    p_txc_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_ev && !txc_we) |=> !txc_flag);

    p_txc_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_ev && txc_we && txc_wval) |=> txc_flag);

    p_rx_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_ev |=> (rx_byte == $past(host_byte)) && rx_strobe);

    p_strobe_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |=> !rx_strobe);
endmodule

// File: rtl/jtag_boot_mailbox.sv
module jtag_boot_mailbox
    import mbx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tck,
    input  logic              tdi,
    input  logic              tap_capture_dr,
    input  logic              tap_shift_dr,
    input  logic              tap_update_dr,
    input  logic              ir_debug_sel,
    input  logic              boot_prog_en,
    input  logic [SRC_W-1:0]  boot_src,
    output logic              tdo,
    output logic              dbg_sm_hold,
    input  logic              cpu_hold_we,
    input  logic [DATA_W-1:0] cpu_hold_data,
    input  logic              cpu_txc_we,
    input  logic              cpu_txc_val,
    output logic              txc,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_strobe
);
    localparam int TAP_W = $bits(tap_in_t);

    tap_in_t   raw, syn;
    logic      active, cap_ev, shf_ev, upd_ev, tdi_bit, tdo_bit;
    mbx_byte_t hold_byte, host_byte;

    always_comb begin
        raw.tck     = tck;
        raw.tdi     = tdi;
        raw.cap     = tap_capture_dr;
        raw.shf     = tap_shift_dr;
        raw.upd     = tap_update_dr;
        raw.ir_dbg  = ir_debug_sel;
        raw.prog_en = boot_prog_en;
        raw.src     = boot_src;
    end

    mbx_in_sync #(.W(TAP_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw),
        .q     (syn)
    );

    mbx_tap_events u_events (
        .clk         (clk),
        .rst_n       (rst_n),
        .s           (syn),
        .mode_hold   (dbg_sm_hold),
        .mode_active (active),
        .cap_ev      (cap_ev),
        .shf_ev      (shf_ev),
        .upd_ev      (upd_ev),
        .tdi_bit     (tdi_bit)
    );

    mbx_shift_stage u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_ev    (cap_ev),
        .shf_ev    (shf_ev),
        .upd_ev    (upd_ev),
        .tdi_bit   (tdi_bit),
        .hold_byte (hold_byte),
        .txc_flag  (txc),
        .tdo_bit   (tdo_bit),
        .host_byte (host_byte)
    );

    mbx_fw_regs u_fw (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_ev     (upd_ev),
        .host_byte  (host_byte),
        .hold_we    (cpu_hold_we),
        .hold_wdata (cpu_hold_data),
        .txc_we     (cpu_txc_we),
        .txc_wval   (cpu_txc_val),
        .hold_byte  (hold_byte),
        .txc_flag   (txc),
        .rx_byte    (rx_byte),
        .rx_strobe  (rx_strobe)
    );

    assign tdo = active ? tdo_bit : 1'b0;

    p_idle_rx_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> $stable(rx_byte) && !rx_strobe);
endmodule

// File: tb/jtag_boot_mailbox_bench.sv
`timescale 1ns/1ps
module jtag_boot_mailbox_bench;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tck = 1'b0, tdi = 1'b0;
    logic       cap = 1'b0, shf = 1'b0, upd = 1'b0;
    logic       ir_dbg = 1'b0, prog_en = 1'b0;
    logic [1:0] src = 2'b00;
    logic       tdo, dbg_hold;
    logic       hold_we = 1'b0, txc_we = 1'b0, txc_val = 1'b0;
    logic [7:0] hold_data = 8'h00;
    logic       txc, rx_strobe;
    logic [7:0] rx_byte;

    int total = 0, bad = 0, pulses = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    jtag_boot_mailbox u_jtag_boot_mailbox (
        .clk(clk), .rst_n(rst_n), .tck(tck), .tdi(tdi),
        .tap_capture_dr(cap), .tap_shift_dr(shf), .tap_update_dr(upd),
        .ir_debug_sel(ir_dbg), .boot_prog_en(prog_en), .boot_src(src),
        .tdo(tdo), .dbg_sm_hold(dbg_hold),
        .cpu_hold_we(hold_we), .cpu_hold_data(hold_data),
        .cpu_txc_we(txc_we), .cpu_txc_val(txc_val),
        .txc(txc), .rx_byte(rx_byte), .rx_strobe(rx_strobe)
    );

    always @(negedge clk) if (rst_n && rx_strobe) pulses++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tck_to(input logic lvl);
        @(negedge clk) tck = lvl;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic fw_write(input logic [7:0] b, input logic flag);
        @(negedge clk);
        hold_we = 1'b1; hold_data = b; txc_we = 1'b1; txc_val = flag;
        @(negedge clk);
        hold_we = 1'b0; txc_we = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // one full DR scan; mid_at >= 0 writes the holding byte mid-shift,
    // collide puts a firmware write in the exact update-event cycle
    task automatic scan(input logic [7:0] hb, input int mid_at, input logic [7:0] mid_b,
                        input bit collide, input logic [7:0] col_b, output logic [9:0] got);
        logic [9:0] w;
        w = {hb, 2'b01};
        @(negedge clk) cap = 1'b1;
        tck_to(1'b1);
        tck_to(1'b0);
        cap = 1'b0; shf = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk) tdi = w[i];
            repeat (HALF) @(negedge clk);
            got[i] = tdo;
            if (i == mid_at) begin
                hold_we = 1'b1; hold_data = mid_b; txc_we = 1'b1; txc_val = 1'b1;
                @(negedge clk);
                hold_we = 1'b0; txc_we = 1'b0;
            end
            tck_to(1'b1);
            tck_to(1'b0);
        end
        shf = 1'b0; upd = 1'b1;
        tck_to(1'b1);
        if (collide) begin
            @(negedge clk) tck = 1'b0;
            repeat (2) @(posedge clk);
            @(negedge clk);
            hold_we = 1'b1; hold_data = col_b; txc_we = 1'b1; txc_val = 1'b1;
            @(negedge clk);
            hold_we = 1'b0; txc_we = 1'b0;
            repeat (HALF) @(negedge clk);
        end else begin
            tck_to(1'b0);
        end
        upd = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R10 txc", txc, 0);
        chk("R10 rx_byte", rx_byte, 0);
        chk("R10 rx_strobe", rx_strobe, 0);
        chk("R1 tdo idle", tdo, 0);
        chk("R2 hold idle", dbg_hold, 0);
    endtask

    task automatic t_mode_gate;
        logic [9:0] got;
        int p0;
        p0 = pulses;
        @(negedge clk) prog_en = 1'b1; src = 2'b00; ir_dbg = 1'b0;
        repeat (6) @(negedge clk);
        chk("R2 hold without debug ir", dbg_hold, 1);
        scan(8'h6E, -1, 8'h00, 1'b0, 8'h00, got);
        chk("R1 tdo without debug ir", got, 0);
        chk("R1 rx without debug ir", rx_byte, 0);
        @(negedge clk) src = 2'b01; ir_dbg = 1'b1;
        repeat (6) @(negedge clk);
        chk("R2 hold with source 01", dbg_hold, 0);
        scan(8'h7F, -1, 8'h00, 1'b0, 8'h00, got);
        chk("R1 tdo with source 01", got, 0);
        chk("R1 rx with source 01", rx_byte, 0);
        chk("R1 no strobe when idle", pulses, p0);
        @(negedge clk) src = 2'b00;
        repeat (6) @(negedge clk);
        chk("R2 hold in mailbox mode", dbg_hold, 1);
    endtask

    task automatic t_first_scan;
        logic [9:0] got;
        int p0;
        p0 = pulses;
        scan(8'hA5, -1, 8'h00, 1'b0, 8'h00, got);
        chk("R10 first word byte 00 busy", got, 10'h002);
        chk("R5 rx after first scan", rx_byte, 8'hA5);
        chk("R9 one strobe", pulses, p0 + 1);
    endtask

    task automatic t_exchange;
        logic [9:0] got;
        fw_write(8'h3C, 1'b1);
        chk("R6 txc set by firmware", txc, 1);
        scan(8'h5A, -1, 8'h00, 1'b0, 8'h00, got);
        chk("R3 busy before exchange", got, 10'h002);
        chk("R6 txc cleared at update", txc, 0);
        chk("R5 rx 5A", rx_byte, 8'h5A);
        scan(8'hC3, -1, 8'h00, 1'b0, 8'h00, got);
        chk("R4 R3 valid word lsb first", got, {8'h3C, 2'b11});
        chk("R5 rx C3", rx_byte, 8'hC3);
    endtask

    task automatic t_midscan;
        logic [9:0] got;
        scan(8'h99, 4, 8'hFF, 1'b0, 8'h00, got);
        chk("R7 word unaffected by mid-scan write", got, {8'h3C, 2'b10});
        chk("R6 txc cleared after mid-scan set", txc, 0);
        chk("R5 rx 99", rx_byte, 8'h99);
    endtask

    task automatic t_collision;
        logic [9:0] got;
        int p0;
        p0 = pulses;
        fw_write(8'hA1, 1'b1);
        scan(8'h11, -1, 8'h00, 1'b1, 8'hB2, got);
        chk("R7 colliding scan output", got, {8'hFF, 2'b11});
        chk("R8 txc survives collision", txc, 1);
        scan(8'h22, -1, 8'h00, 1'b0, 8'h00, got);
        chk("R8 old holding byte sent", got, {8'hA1, 2'b11});
        chk("R6 txc cleared after collision", txc, 0);
        scan(8'h33, -1, 8'h00, 1'b0, 8'h00, got);
        chk("R8 collision byte sent next", got, {8'hB2, 2'b11});
        scan(8'h44, -1, 8'h00, 1'b0, 8'h00, got);
        chk("R3 busy after flag cleared", got, {8'hB2, 2'b10});
        chk("R5 rx 44", rx_byte, 8'h44);
        chk("R9 four strobes", pulses, p0 + 4);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_mode_gate();
        @(negedge clk) ir_dbg = 1'b1;
        repeat (6) @(negedge clk);
        t_first_scan();
        t_exchange();
        t_midscan();
        t_collision();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule